// File: doc/BRIEF.md
# Configuration channel transaction controller

This block runs single-shot transfers between a staging data register and a small bank of clock-setting words. Software first loads the outgoing data word. It then writes a control word that names a target index, a function code, a direction and a start flag. The block checks the request in the same clock edge and moves the data. It leaves a two-bit status showing completion and rejection. A read result goes into a return-data word.

The clock-setting bank has `N_CLK` entries, each with its own reset value taken from a parameter. Every entry is driven out on a flat bus so that the clock generators around the block can use the settings directly. Address decoding of the register interface is done by the host fabric, which gives the block one write strobe per register.

Top module: `cfg_chan_ctrl`

## Requirements
- R1: After reset, the stored control word reads 0x00100000, and the status, data-out and return-data words read 0. Each clock-setting word i holds its reset value, `CLK_RST[i*32 +: 32]`.
- R2: A control write stores only the index field [11:0], the function field [25:20] and the direction bit [30]. Bits [19:12], [29:26] and the start bit [31] always read back as 0.
- R3: Every control write clears the status. If bit 31 of that write is 0, the status stays 0.
- R4: A control write with bit 31 set sets status bit 0 (done). It also sets status bit 1 (error) when the request is rejected.
- R5: A request is accepted only when the function field equals 1 and the index is below `N_CLK`. All other requests are rejected.
- R6: An accepted request with bit 30 set copies the data-out word into the clock-setting word selected by the index. No other clock-setting word changes.
- R7: An accepted request with bit 30 clear copies the selected clock-setting word into the return-data word. A rejected read, and any write request, leave the return-data word unchanged.
- R8: A rejected request changes no clock-setting word.
- R9: Status and return data appear on the cycle after the control write. They hold their values until the next control write.
- R10: A data-out write stores its value. When it coincides with a control write, the transfer uses the data-out value held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dout_we | input | 1 | Data-out word write strobe |
| dout_wdata | input | 32 | Data-out write value |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 32 | Control write value |
| dout_q | output | 32 | Current data-out word |
| ctrl_q | output | 32 | Stored control word |
| stat_q | output | 2 | Status: bit 0 done, bit 1 error |
| rtn_q | output | 32 | Return-data word |
| clk_words | output | N_CLK*32 | All clock-setting words, entry i at [i*32 +: 32] |

## Verification
The bench sweeps four function codes (0, 1, 2 and 63) against every index from 0 up to two past the bank size, plus the largest index. It issues both a write and a read for each combination. This separates the function check from the range check, and it shows whether a rejected request still touches the bank or the return word. Every control word is sent with all reserved bits set, so a leak of a reserved bit or of the start bit into the stored control is visible. Further cases cover writes without start, status hold across idle cycles, and a data-out write in the same cycle as a transfer.

// File: rtl/cfg_chan_ctrl.sv
module cfg_chan_ctrl #(
  parameter int N_CLK = 4,
  parameter int DW = 32,
  parameter logic [16*DW-1:0] CLK_RST = '0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                dout_we,
  input  logic [31:0]         dout_wdata,
  input  logic                ctrl_we,
  input  logic [31:0]         ctrl_wdata,
  output logic [31:0]         dout_q,
  output logic [31:0]         ctrl_q,
  output logic [1:0]          stat_q,
  output logic [31:0]         rtn_q,
  output logic [N_CLK*DW-1:0] clk_words
);
  localparam logic [31:0] KEEP_MASK = 32'h43F0_0FFF;
  localparam logic [31:0] CTRL_RST  = 32'h0010_0000;

  logic [11:0]   idx;
  logic [5:0]    fn;
  logic          go, dir_wr, ok;
  logic [DW-1:0] sel_word;

  assign idx    = ctrl_wdata[11:0];
  assign fn     = ctrl_wdata[25:20];
  assign dir_wr = ctrl_wdata[30];
  assign go     = ctrl_we & ctrl_wdata[31];
  assign ok     = (fn == 6'd1) && (32'(idx) < N_CLK);

  always_comb begin
    sel_word = '0;
    for (int i = 0; i < N_CLK; i++)
      if (32'(idx) == i) sel_word = clk_words[i*DW +: DW];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout_q <= '0;
      ctrl_q <= CTRL_RST;
      stat_q <= '0;
      rtn_q  <= '0;
    end else begin
      if (dout_we) dout_q <= dout_wdata;
      if (ctrl_we) begin
        ctrl_q <= ctrl_wdata & KEEP_MASK;
        stat_q <= go ? {~ok, 1'b1} : 2'b00;
        if (go && ok && !dir_wr) rtn_q <= 32'(sel_word);
      end
    end
  end

  for (genvar g = 0; g < N_CLK; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)
        clk_words[g*DW +: DW] <= CLK_RST[g*DW +: DW];
      else if (go && ok && dir_wr && 32'(idx) == g)
        clk_words[g*DW +: DW] <= dout_q[DW-1:0];
    end
  end
endmodule

// File: rtl/cfg_chan_ctrl_chk.sv
module cfg_chan_ctrl_chk #(
  parameter int W = 128
) (
  input logic         clk,
  input logic         rst_n,
  input logic         ctrl_we,
  input logic [31:0]  ctrl_wdata,
  input logic [31:0]  ctrl_q,
  input logic [1:0]   stat_q,
  input logic [31:0]  rtn_q,
  input logic [W-1:0] clk_words
);
  // R2
  ctrl_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> (ctrl_q[31] == 1'b0) && (ctrl_q[19:12] == 8'h0) && (ctrl_q[29:26] == 4'h0));
  // R3
  stat_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && !ctrl_wdata[31]) |=> (stat_q == 2'b00));
  // R4
  done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && ctrl_wdata[31]) |=> stat_q[0]);
  // R4
  err_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q[1] |-> stat_q[0]);
  // R9
  stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_we |=> ($stable(stat_q) && $stable(rtn_q)));
  // R8
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_we |=> $stable(clk_words));
endmodule

bind cfg_chan_ctrl cfg_chan_ctrl_chk #(.W(N_CLK*DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
  .ctrl_q(ctrl_q), .stat_q(stat_q), .rtn_q(rtn_q), .clk_words(clk_words)
);

// File: tb/cfg_chan_ctrl_tb_top.sv
`timescale 1ns/1ps
module cfg_chan_ctrl_tb_top;
  localparam int N = 4;

  function automatic logic [511:0] mk_rst();
    logic [511:0] v = '0;
    for (int i = 0; i < 16; i++) v[i*32 +: 32] = 32'h1000_0000 + 32'(i) * 32'h0101_0011;
    return v;
  endfunction
  localparam logic [511:0] RST_VALS = mk_rst();

  logic clk = 0, rst_n = 0;
  logic dout_we = 0, ctrl_we = 0;
  logic [31:0] dout_wdata = 0, ctrl_wdata = 0;
  logic [31:0] dout_q, ctrl_q, rtn_q;
  logic [1:0]  stat_q;
  logic [N*32-1:0] clk_words;

  int checks = 0, errors = 0;
  logic [31:0] m_clk [N];
  logic [31:0] m_rtn, m_dout;

  always #4 clk = ~clk;

  cfg_chan_ctrl #(.N_CLK(N), .DW(32), .CLK_RST(RST_VALS)) dut_i (
    .clk(clk), .rst_n(rst_n), .dout_we(dout_we), .dout_wdata(dout_wdata),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .dout_q(dout_q), .ctrl_q(ctrl_q),
    .stat_q(stat_q), .rtn_q(rtn_q), .clk_words(clk_words));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_bank(string req);
    for (int i = 0; i < N; i++) chk(req, clk_words[i*32 +: 32], m_clk[i]);
  endtask

  task automatic put_dout(logic [31:0] v);
    @(negedge clk); dout_we = 1; dout_wdata = v;
    @(negedge clk); dout_we = 0;
    m_dout = v;
  endtask

  task automatic put_ctrl(logic go, logic wr, logic [5:0] fn, logic [11:0] dev);
    logic acc;
    @(negedge clk);
    ctrl_we = 1;
    ctrl_wdata = {go, wr, 4'hF, fn, 8'hFF, dev};
    @(negedge clk); ctrl_we = 0;
    acc = (fn == 6'd1) && (dev < N);
    chk("R2", ctrl_q, {1'b0, wr, 4'h0, fn, 8'h00, dev});
    if (!go) chk("R3", {30'd0, stat_q}, 32'd0);
    else chk("R4", {30'd0, stat_q}, {30'd0, !acc, 1'b1});
    if (go && acc && wr) m_clk[dev] = m_dout;
    if (go && acc && !wr) m_rtn = m_clk[dev];
    chk("R7", rtn_q, m_rtn);
    chk_bank(acc ? "R6" : "R8");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [5:0] fns [4];
    int k;
    fns[0] = 6'd0; fns[1] = 6'd1; fns[2] = 6'd2; fns[3] = 6'd63;
    for (int i = 0; i < N; i++) m_clk[i] = RST_VALS[i*32 +: 32];
    m_rtn = 0; m_dout = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk("R1", ctrl_q, 32'h0010_0000);
    chk("R1", {30'd0, stat_q}, 32'd0);
    chk("R1", dout_q, 32'd0);
    chk("R1", rtn_q, 32'd0);
    chk_bank("R1");

    // R5 sweep over function and index
    k = 0;
    for (int f = 0; f < 4; f++)
      for (int d = 0; d <= N + 2; d++) begin
        logic [11:0] dv = (d == N + 2) ? 12'hFFF : 12'(d);
        put_dout(32'hD000_0000 + 32'(k) * 32'h0001_0203);
        chk("R10", dout_q, m_dout);
        put_ctrl(1'b1, 1'b1, fns[f], dv);
        put_ctrl(1'b1, 1'b0, fns[f], dv);
        k++;
      end

    // R3 no start after a rejected request
    put_ctrl(1'b1, 1'b0, 6'd2, 12'd0);
    put_ctrl(1'b0, 1'b1, 6'd1, 12'd1);
    put_ctrl(1'b0, 1'b0, 6'd1, 12'd2);

    // R9 hold over idle cycles
    put_ctrl(1'b1, 1'b0, 6'd1, 12'd3);
    repeat (4) @(negedge clk);
    chk("R9", {30'd0, stat_q}, 32'd1);
    chk("R9", rtn_q, m_rtn);
    put_ctrl(1'b1, 1'b1, 6'd1, 12'd7);
    repeat (3) @(negedge clk);
    chk("R9", {30'd0, stat_q}, 32'd3);

    // R10 simultaneous data-out and control write
    put_dout(32'hAAAA_5555);
    @(negedge clk);
    dout_we = 1; dout_wdata = 32'h1234_5678;
    ctrl_we = 1; ctrl_wdata = {1'b1, 1'b1, 4'h0, 6'd1, 8'h00, 12'd1};
    @(negedge clk); dout_we = 0; ctrl_we = 0;
    m_clk[1] = 32'hAAAA_5555; m_dout = 32'h1234_5678;
    chk("R10", clk_words[1*32 +: 32], 32'hAAAA_5555);
    chk("R10", dout_q, 32'h1234_5678);
    chk_bank("R10");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule